// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a 16-bit accumulator processor. It keeps a control address register that points into a read-only control store. Each clock it presents one 32-bit control word to the datapath. Every machine instruction uses the same routine. A common fetch sequence reads the instruction. A decode word then jumps through an opcode map to that instruction's execute routine. The routine ends by returning to fetch.

Three low bits of each control word choose the next control address. The options are: step forward, jump through the opcode map, return to fetch, branch on the accumulator sign, or hold. The conditional jump instruction branches on the sign bit of the accumulator. The halt instruction freezes the sequencer until reset. The datapath, the memory and the ALU sit outside the block. They only consume the control lines.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous reset clears the control address to 0 and clears `halted`. While the address is 0, `ctrl` shows the first fetch word, 0x00000008.
- R2: The transfer lines sit at these bit positions:
  - bit 3: PC to address register.
  - bit 4: memory read into the buffer register.
  - bit 5: PC increment.
  - bit 6: buffer to instruction register.
  - bit 7: instruction address field to address register.
  - bit 8: buffer to ALU operand register.
  - bit 9: accumulator to buffer.
  - bit 10: memory write.
  - bit 11: instruction address field to PC.

  Every instruction starts with the four words 0x00000008, 0x00000030, 0x00000040, 0x00000001, one per cycle.
- R3: Bits 2..0 select the next control address:
  - 000: address plus one.
  - 001: start of the routine for `opcode`.
  - 010: address 0.
  - 011: branch.
  - 100: hold and set `halted`.
- R4: Bit 15 loads the accumulator. Bits 19..16 carry the ALU function code, in the order pass, add, sub, mul, and, or, not, shift-right, shift-left (codes 0..8). Opcodes 2, 3, 4, 8, 10, 11, 12, 13 and 14 each run four words after decode: 0x00000080, 0x00000010, 0x00000100, then 0x00008002 | (code << 16). The codes for these opcodes are load=0, add=1, sub=2, mul=3, and=4, or=5, not=6, shift-right=7 and shift-left=8.
- R5: Opcode 1 (store) runs 0x00000280 and then 0x00000402. The sequencer then returns to fetch.
- R6: Opcode 6 (jump) runs a single word, 0x00000802, and then returns to fetch.
- R7: Opcode 5 (jump if non-negative) runs the word 0x00000003. If `acc_sign` is 0, the next word is 0x00000802 and the sequencer then returns to fetch. If `acc_sign` is 1, the next word is the fetch word 0x00000008.
- R8: Opcode 7 shows the word 0x00000004. From the next cycle on, `halted` is 1 and the word stays 0x00000004, whatever the inputs do, until reset.
- R9: An undefined opcode (0, 9, or 15 to 255) returns to fetch straight after the decode word, so the next word is 0x00000008.
- R10: Bits 31..22, 21, 20 and 14..12 are 0 in every word the store issues.
- R11: `opcode` is used only during the decode word, and `acc_sign` only during the branch word. Changing either at any other time does not alter the sequence of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode field of the instruction register |
| acc_sign | input | 1 | Sign bit of the accumulator |
| ctrl | output | 32 | Control word for the current control address |
| halted | output | 1 | Sticky halt indication |

## Verification
Two functions can fall in the same cycle: the choice of the next control address, and a change on `opcode` or `acc_sign` that must not steer it. The bench makes the second happen in two ways. It changes `opcode` and the sign bit in the middle of an execute routine. It also toggles both inputs while the sequencer is halted. It then judges the outcome by comparing every control word, cycle by cycle, against the sequence the requirements predict. The bench also drives both values of the sign bit into the same conditional-branch word, and feeds undefined opcodes into the decode word, to check that each chooses the right successor.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UW_W      = 32;
    localparam int FETCH_LEN = 4;

    // transfer line positions
    localparam int L_PC_MAR  = 3;
    localparam int L_MEM_RD  = 4;
    localparam int L_PC_INC  = 5;
    localparam int L_MBR_IR  = 6;
    localparam int L_IRA_MAR = 7;
    localparam int L_MBR_BR  = 8;
    localparam int L_ACC_MBR = 9;
    localparam int L_MEM_WR  = 10;
    localparam int L_IRA_PC  = 11;
    localparam int L_ACC_LD  = 15;
    localparam int F_ALU_LSB = 16;

    // opcodes
    localparam int OP_STORE = 1;
    localparam int OP_LOAD  = 2;
    localparam int OP_ADD   = 3;
    localparam int OP_SUB   = 4;
    localparam int OP_JGEZ  = 5;
    localparam int OP_JMP   = 6;
    localparam int OP_HALT  = 7;
    localparam int OP_MPY   = 8;
    localparam int OP_AND   = 10;
    localparam int OP_OR    = 11;
    localparam int OP_NOT   = 12;
    localparam int OP_SHR   = 13;
    localparam int OP_SHL   = 14;
    localparam int OP_LAST  = 14;

    typedef enum logic [2:0] {
        SQ_NEXT   = 3'b000,
        SQ_MAP    = 3'b001,
        SQ_FETCH  = 3'b010,
        SQ_BRANCH = 3'b011,
        SQ_HOLD   = 3'b100
    } seq_e;

    function automatic logic [UW_W-1:0] bitv(input int p);
        return UW_W'(1) << p;
    endfunction

    function automatic logic op_defined(input int op);
        return (op >= 1) && (op <= OP_LAST) && (op != 9);
    endfunction

    function automatic int routine_len(input int op);
        case (op)
            OP_STORE: return 2;
            OP_JGEZ, OP_JMP, OP_HALT: return 1;
            default: return 4;
        endcase
    endfunction

    function automatic int routine_start(input int op);
        int s;
        s = FETCH_LEN;
        for (int k = 1; k <= OP_LAST; k++) begin
            if (k < op && op_defined(k)) s += routine_len(k);
        end
        return s;
    endfunction

    function automatic int alu_func(input int op);
        case (op)
            OP_ADD: return 1;
            OP_SUB: return 2;
            OP_MPY: return 3;
            OP_AND: return 4;
            OP_OR:  return 5;
            OP_NOT: return 6;
            OP_SHR: return 7;
            OP_SHL: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [UW_W-1:0] routine_word(input int op, input int off);
        case (op)
            OP_STORE: return (off == 0) ? (bitv(L_IRA_MAR) | bitv(L_ACC_MBR))
                                        : (bitv(L_MEM_WR) | UW_W'(SQ_FETCH));
            OP_JGEZ:  return UW_W'(SQ_BRANCH);
            OP_JMP:   return bitv(L_IRA_PC) | UW_W'(SQ_FETCH);
            OP_HALT:  return UW_W'(SQ_HOLD);
            default: begin
                case (off)
                    0: return bitv(L_IRA_MAR);
                    1: return bitv(L_MEM_RD);
                    2: return bitv(L_MBR_BR);
                    default: return bitv(L_ACC_LD)
                                  | (UW_W'(alu_func(op)) << F_ALU_LSB)
                                  | UW_W'(SQ_FETCH);
                endcase
            end
        endcase
    endfunction

    function automatic logic [UW_W-1:0] ucode_word(input int a);
        logic [UW_W-1:0] w;
        int s;
        w = '0;
        case (a)
            0: w = bitv(L_PC_MAR);
            1: w = bitv(L_MEM_RD) | bitv(L_PC_INC);
            2: w = bitv(L_MBR_IR);
            3: w = UW_W'(SQ_MAP);
            default: begin
                for (int op = 1; op <= OP_LAST; op++) begin
                    if (op_defined(op)) begin
                        s = routine_start(op);
                        if (a >= s && a < s + routine_len(op))
                            w = routine_word(op, a - s);
                    end
                end
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int CS_DEPTH = 72,
    localparam int CA_W = $clog2(CS_DEPTH)
) (
    input  logic [CA_W-1:0] addr,
    output logic [UW_W-1:0] word
);

    logic [UW_W-1:0] rom [CS_DEPTH];

    for (genvar i = 0; i < CS_DEPTH; i++) begin : g_word
        assign rom[i] = ucode_word(i);
    end

    always_comb begin
        word = '0;
        if (int'(addr) < CS_DEPTH) word = rom[addr];
    end

endmodule

// File: rtl/useq_mapper.sv
module useq_mapper
    import useq_pkg::*;
#(
    parameter int OP_W = 8,
    parameter int CA_W = 7
) (
    input  logic [OP_W-1:0] opcode,
    output logic [CA_W-1:0] start
);

    always_comb begin
        start = '0;
        for (int k = 1; k <= OP_LAST; k++) begin
            if (op_defined(k) && opcode == OP_W'(k))
                start = CA_W'(routine_start(k));
        end
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int CS_DEPTH = 72,
    parameter int OP_W     = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            acc_sign,
    output logic [UW_W-1:0] ctrl,
    output logic            halted
);

    localparam int CA_W = $clog2(CS_DEPTH);
    localparam logic [CA_W-1:0] BR_TARGET = CA_W'(routine_start(OP_JMP));

    typedef struct packed {
        logic [CA_W-1:0] car;
        logic            halted;
    } state_t;

    state_t st_d, st_q;
    logic [UW_W-1:0] word;
    logic [CA_W-1:0] map_start;
    seq_e            seq;

    useq_store #(.CS_DEPTH(CS_DEPTH)) u_store (
        .addr (st_q.car),
        .word (word)
    );

    useq_mapper #(.OP_W(OP_W), .CA_W(CA_W)) u_map (
        .opcode (opcode),
        .start  (map_start)
    );

    assign seq = seq_e'(word[2:0]);

    always_comb begin
        st_d = st_q;
        case (seq)
            SQ_NEXT:   st_d.car = st_q.car + 1'b1;
            SQ_MAP:    st_d.car = map_start;
            SQ_FETCH:  st_d.car = '0;
            SQ_BRANCH: st_d.car = acc_sign ? '0 : BR_TARGET;
            SQ_HOLD:   st_d.halted = 1'b1;
            default:   st_d.car = '0;
        endcase
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ctrl   = word;
    assign halted = st_q.halted;

    // R1: reset clears address and halt flag
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (st_q.car == '0 && !st_q.halted));

    // R3: increment step
    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        (seq == SQ_NEXT) |=> (st_q.car == $past(st_q.car) + 1'b1));

    // R7: negative accumulator returns to fetch
    a_r7_neg_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (seq == SQ_BRANCH && acc_sign) |=> (st_q.car == '0));

    // R8: halt is sticky, address frozen, transfers idle
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(st_q.car));
    a_r8_no_transfer: assert property (@(posedge clk) disable iff (rst)
        halted |-> (ctrl[14:3] == '0));

    // R9: undefined opcode goes back to fetch
    a_r9_undef_fetch: assert property (@(posedge clk) disable iff (rst)
        (seq == SQ_MAP && !op_defined(int'(opcode))) |=> (st_q.car == '0));

    // R10: unused lines stay low
    a_r10_unused_low: assert property (@(posedge clk) disable iff (rst)
        (ctrl[31:20] == '0) && (ctrl[14:12] == '0));

endmodule

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  opcode;
    logic        acc_sign;
    logic [31:0] ctrl;
    logic        halted;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam logic [31:0] W_F0 = 32'h0000_0008;
    localparam logic [31:0] W_F1 = 32'h0000_0030;
    localparam logic [31:0] W_F2 = 32'h0000_0040;
    localparam logic [31:0] W_DEC = 32'h0000_0001;

    always #2.5 clk = ~clk;

    useq_ctrl u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .acc_sign(acc_sign),
        .ctrl(ctrl), .halted(halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // check current word, then advance to next negedge
    task automatic expect_word(input string req, input logic [31:0] exp);
        chk(req, ctrl, exp);
        @(negedge clk);
    endtask

    task automatic do_fetch(input logic [7:0] op, input logic sgn);
        opcode   = op;
        acc_sign = sgn;
        expect_word("R2 fetch0", W_F0);
        expect_word("R2 fetch1", W_F1);
        expect_word("R2 fetch2", W_F2);
        expect_word("R2 decode", W_DEC);
    endtask

    task automatic t_reset;
        rst = 1'b1; opcode = 8'd0; acc_sign = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 word", ctrl, W_F0);
        chk("R1 halted", {31'd0, halted}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_operand(input logic [7:0] op, input int fcode, input logic sgn);
        do_fetch(op, sgn);
        expect_word("R4 w0", 32'h0000_0080);
        expect_word("R4 w1", 32'h0000_0010);
        expect_word("R4 w2", 32'h0000_0100);
        expect_word("R4 w3", 32'h0000_8002 | (32'(fcode) << 16));
    endtask

    task automatic t_all_operand;
        t_operand(8'd2, 0, 1'b0);
        t_operand(8'd3, 1, 1'b1);
        t_operand(8'd4, 2, 1'b0);
        t_operand(8'd8, 3, 1'b1);
        t_operand(8'd10, 4, 1'b0);
        t_operand(8'd11, 5, 1'b1);
        t_operand(8'd12, 6, 1'b0);
        t_operand(8'd13, 7, 1'b1);
        t_operand(8'd14, 8, 1'b0);
    endtask

    task automatic t_store;
        do_fetch(8'd1, 1'b0);
        expect_word("R5 w0", 32'h0000_0280);
        expect_word("R5 w1", 32'h0000_0402);
    endtask

    task automatic t_jmp;
        do_fetch(8'd6, 1'b1);
        expect_word("R6 w0", 32'h0000_0802);
    endtask

    task automatic t_jgez_taken;
        do_fetch(8'd5, 1'b0);
        expect_word("R7 branch", 32'h0000_0003);
        expect_word("R7 taken", 32'h0000_0802);
        chk("R7 back to fetch", ctrl, W_F0);
    endtask

    task automatic t_jgez_not;
        do_fetch(8'd5, 1'b1);
        expect_word("R7 branch", 32'h0000_0003);
        chk("R7 not taken", ctrl, W_F0);
    endtask

    task automatic t_undefined;
        logic [7:0] ops [5] = '{8'd0, 8'd9, 8'd15, 8'd200, 8'd255};
        foreach (ops[i]) begin
            do_fetch(ops[i], 1'b0);
            chk("R9 undefined returns", ctrl, W_F0);
        end
    endtask

    // R11: opcode and sign changed mid-routine do not steer it
    task automatic t_inputs_ignored;
        do_fetch(8'd3, 1'b0);
        opcode = 8'd6; acc_sign = 1'b1;
        expect_word("R11 w0", 32'h0000_0080);
        opcode = 8'd7;
        expect_word("R11 w1", 32'h0000_0010);
        opcode = 8'd0; acc_sign = 1'b0;
        expect_word("R11 w2", 32'h0000_0100);
        expect_word("R11 w3", 32'h0001_8002);
        chk("R11 fetch", ctrl, W_F0);
    endtask

    task automatic t_halt;
        do_fetch(8'd7, 1'b0);
        chk("R8 halt word", ctrl, 32'h0000_0004);
        chk("R8 halted not yet", {31'd0, halted}, 32'd0);
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            opcode   = 8'(i * 3);
            acc_sign = i[0];
            chk("R8 held word", ctrl, 32'h0000_0004);
            chk("R8 halted", {31'd0, halted}, 32'd1);
            chk("R10 unused lines low", ctrl & 32'hFFF0_7000, 32'd0);
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset after halt word", ctrl, W_F0);
        chk("R1 reset clears halted", {31'd0, halted}, 32'd0);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_all_operand();
        t_store();
        t_jmp();
        t_jgez_taken();
        t_jgez_not();
        t_undefined();
        t_inputs_ignored();
        t_halt();
        do_fetch(8'd2, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule